// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Flow-Control Status

This block turns an asynchronous serial line into characters held in a small receive queue. It runs from a 16x oversampling tick supplied from outside. It finds each start bit and confirms it, shifts in the data bits least significant first, and handles an optional extra bit. That bit is checked as parity or kept as an address/data marker. The stop bit is then checked. Each stored character carries four flags: line break, bad stop bit, parity mismatch and address marker.

The status outputs describe the queue head in one of two ways. In per-character mode they show the flags of the head character only. In accumulating mode they show the OR of the error flags of every character that has reached the head since the last clear. An interrupt line reports either "queue full" or "data available", as configured. The block also drives an active-low request-to-send output. Software can set it directly. The receiver can instead drive it, dropping it when a new character starts while no slot is free.

Top module: `sio_receiver`

## Requirements
- R1: A low level seen on a tick starts a start bit, and the line is sampled again 8 ticks later. If the line is high at that second sample, the receiver returns to idle and stores nothing.
- R2: Characters are 8 data bits, least significant bit first, one bit per 16 ticks. They leave the 4-entry queue in arrival order through rd_data. rd_valid is high when the queue holds a character, and a high rd_en pops the head. fifo_full does not drop unless a pop occurs.
- R3: cfg_par_mode selects how the extra bit after the data is handled: 00 checked parity, 01 forced parity, 10 no extra bit, 11 multidrop. With 00, cfg_par_type 0 means even parity and 1 means odd parity. With 01, the bit must equal cfg_par_type. A mismatch sets the parity flag of that character.
- R4: In multidrop mode the extra bit is stored as the address flag and never raises a parity error. st_addr shows the head's address flag only when cfg_blk_err is 0, and is 0 otherwise.
- R5: A low stop bit sets the framing flag. If the data bits, any extra bit and the stop bit are all 0, the break flag is also set. After a low stop bit the receiver waits for the line to go high before it looks for a new start.
- R6: When cfg_blk_err is 0, st_break, st_frame and st_parity show the head character's flags, and are 0 when the queue is empty.
- R7: When cfg_blk_err is 1, st_break, st_frame and st_parity are the OR of the flags of every character that has reached the queue head since the last clr_err pulse. A clr_err pulse sets them to 0.
- R8: A character that completes while the queue is full is discarded and sets st_overrun. st_overrun stays set until clr_err.
- R9: irq equals fifo_full when cfg_irq_full is 1, and equals rd_valid when cfg_irq_full is 0.
- R10: With cfg_rx_rts_auto=1 and cfg_tx_rts_auto=0, rts_n goes high on a confirmed start bit while the queue is full. It goes low one cycle after the queue has a free slot.
- R11: When automatic control is not in effect (cfg_rx_rts_auto=0, or both cfg_rx_rts_auto and cfg_tx_rts_auto are 1), rts_n is the inverse of sw_rts_on, one cycle later.
- R12: While reset is applied, and until the first character arrives, rd_valid, irq and all status outputs are 0, and rts_n is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | 16x oversampling enable |
| rxd | input | 1 | Serial line, idle high |
| cfg_par_mode | input | 2 | Extra-bit handling: 00 parity, 01 forced, 10 none, 11 multidrop |
| cfg_par_type | input | 1 | Parity sense or forced value |
| cfg_blk_err | input | 1 | 1 = accumulating status, 0 = per character |
| cfg_irq_full | input | 1 | 1 = interrupt on full, 0 = on data available |
| cfg_rx_rts_auto | input | 1 | Receiver drives rts_n |
| cfg_tx_rts_auto | input | 1 | Transmitter claims rts_n |
| sw_rts_on | input | 1 | Software request-to-send level |
| clr_err | input | 1 | Clears accumulated status and overrun |
| rd_en | input | 1 | Pop the queue head |
| rd_data | output | 8 | Head character, 0 when empty |
| rd_valid | output | 1 | Queue not empty |
| fifo_full | output | 1 | Queue full |
| st_break | output | 1 | Break status |
| st_frame | output | 1 | Framing error status |
| st_parity | output | 1 | Parity error status |
| st_addr | output | 1 | Multidrop address flag of head |
| st_overrun | output | 1 | Sticky overrun |
| irq | output | 1 | Receive interrupt request |
| rts_n | output | 1 | Active-low request to send |

## Verification
The bench sends a start pulse only 4 ticks long. A receiver that did not confirm at mid-bit would store a spurious character. It switches between status modes while an older parity error sits behind a clean head. Wrong accumulation would either drop the stale error or never clear it on clr_err. It fills the queue and sends one more character. A faulty design would overwrite the head, miss the overrun, or keep rts_n high after a slot frees up. It also turns on both automatic controls together, where rts_n must follow software again. Random frames with random parity bits and occasional low stop bits, sent under every extra-bit mode, are compared against a bench model of the queue.

// File: rtl/sio_rx_pkg.sv
package sio_rx_pkg;

  typedef struct packed {
    logic brk;
    logic fe;
    logic pe;
    logic adr;
  } rx_flags_t;

  typedef enum logic [1:0] {
    PAR_NORMAL = 2'b00,
    PAR_FORCED = 2'b01,
    PAR_NONE   = 2'b10,
    PAR_MDROP  = 2'b11
  } par_sel_e;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_HOLD
  } rx_state_e;

endpackage

// File: rtl/sio_rx_deser.sv
module sio_rx_deser
  import sio_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd,
  input  logic [1:0]        par_sel,
  input  logic              par_kind,
  output logic              start_ok,
  output logic              chr_vld,
  output logic [DATA_W-1:0] chr_data,
  output rx_flags_t         chr_flags
);

  localparam int CNT_W = $clog2(OVS);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(OVS/2 - 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OVS - 1);
  localparam logic [IDX_W-1:0] TOP  = IDX_W'(DATA_W - 1);

  rx_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              pbit_q, pbit_d;
  logic              has_par;
  logic              pbit_eff;
  logic              exp_par;

  assign has_par  = (par_sel != PAR_NONE);
  assign pbit_eff = has_par & pbit_q;
  assign exp_par  = (par_sel == PAR_FORCED) ? par_kind : ((^sh_q) ^ par_kind);

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    idx_d    = idx_q;
    sh_d     = sh_q;
    pbit_d   = pbit_q;
    start_ok = 1'b0;
    chr_vld  = 1'b0;
    if (tick) begin
      case (state_q)
        S_IDLE: begin
          if (!rxd) begin
            state_d = S_START;
            cnt_d   = '0;
          end
        end
        S_START: begin
          if (cnt_q == MID) begin
            cnt_d = '0;
            if (!rxd) begin
              state_d  = S_DATA;
              idx_d    = '0;
              start_ok = 1'b1;
            end else begin
              state_d = S_IDLE;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        S_DATA: begin
          if (cnt_q == LAST) begin
            cnt_d = '0;
            sh_d  = {rxd, sh_q[DATA_W-1:1]};
            if (idx_q == TOP) state_d = has_par ? S_PAR : S_STOP;
            else              idx_d   = idx_q + 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        S_PAR: begin
          if (cnt_q == LAST) begin
            cnt_d   = '0;
            pbit_d  = rxd;
            state_d = S_STOP;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        S_STOP: begin
          if (cnt_q == LAST) begin
            cnt_d   = '0;
            chr_vld = 1'b1;
            state_d = rxd ? S_IDLE : S_HOLD;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        S_HOLD: begin
          if (rxd) state_d = S_IDLE;
        end
        default: state_d = S_IDLE;
      endcase
    end
  end

  // character record, valid together with chr_vld
  always_comb begin
    chr_data      = sh_q;
    chr_flags.fe  = ~rxd;
    chr_flags.brk = ~rxd & (sh_q == '0) & ~pbit_eff;
    chr_flags.pe  = ((par_sel == PAR_NORMAL) || (par_sel == PAR_FORCED)) & (pbit_q != exp_par);
    chr_flags.adr = (par_sel == PAR_MDROP) & pbit_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      pbit_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      sh_q    <= sh_d;
      pbit_q  <= pbit_d;
    end
  end

endmodule

// File: rtl/sio_rx_fifo.sv
module sio_rx_fifo
  import sio_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  rx_flags_t         wr_flags,
  input  logic              rd_en,
  output logic [DATA_W-1:0] head_data,
  output rx_flags_t         head_flags,
  output logic              empty,
  output logic              full,
  output logic              arr_vld,
  output logic [2:0]        arr_err
);

  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] ONE = (AW+1)'(1);

  logic [DATA_W-1:0] dmem_q [DEPTH];
  rx_flags_t         fmem_q [DEPTH];
  logic [AW:0]       wptr_q, wptr_d, rptr_q, rptr_d;
  logic [AW:0]       count;
  logic [AW-1:0]     nxt_idx;
  logic              push, pop;
  rx_flags_t         nxt_flags;

  assign count   = wptr_q - rptr_q;
  assign empty   = (count == '0);
  assign full    = (count == (AW+1)'(DEPTH));
  assign push    = wr_en & ~full;
  assign pop     = rd_en & ~empty;
  assign nxt_idx = rptr_q[AW-1:0] + 1'b1;

  assign head_data  = dmem_q[rptr_q[AW-1:0]];
  assign head_flags = fmem_q[rptr_q[AW-1:0]];
  assign nxt_flags  = fmem_q[nxt_idx];

  always_comb begin
    wptr_d = wptr_q + (push ? ONE : '0);
    rptr_d = rptr_q + (pop  ? ONE : '0);
  end

  // record that becomes the head at the coming edge
  always_comb begin
    arr_vld = 1'b0;
    arr_err = '0;
    if (push && (empty || (pop && count == ONE))) begin
      arr_vld = 1'b1;
      arr_err = {wr_flags.brk, wr_flags.fe, wr_flags.pe};
    end else if (pop && count > ONE) begin
      arr_vld = 1'b1;
      arr_err = {nxt_flags.brk, nxt_flags.fe, nxt_flags.pe};
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      dmem_q[wptr_q[AW-1:0]] <= wr_data;
      fmem_q[wptr_q[AW-1:0]] <= wr_flags;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
    end
  end

endmodule

// File: rtl/sio_rx_ctl.sv
module sio_rx_ctl
  import sio_rx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start_ok,
  input  logic      chr_vld,
  input  logic      q_empty,
  input  logic      q_full,
  input  logic      arr_vld,
  input  logic [2:0] arr_err,
  input  rx_flags_t head_flags,
  input  logic      cfg_blk_err,
  input  logic      cfg_irq_full,
  input  logic      cfg_rx_rts_auto,
  input  logic      cfg_tx_rts_auto,
  input  logic      sw_rts_on,
  input  logic      clr_err,
  output logic      st_break,
  output logic      st_frame,
  output logic      st_parity,
  output logic      st_addr,
  output logic      st_overrun,
  output logic      irq,
  output logic      rts_n
);

  logic [2:0] acc_q, acc_d;
  logic       ovr_q, ovr_d;
  logic       rts_n_q, rts_n_d;
  logic       auto_on;
  logic [2:0] head_err;

  assign auto_on  = cfg_rx_rts_auto & ~cfg_tx_rts_auto;
  assign head_err = q_empty ? 3'b000 : {head_flags.brk, head_flags.fe, head_flags.pe};

  always_comb begin
    acc_d = (clr_err ? 3'b000 : acc_q) | (arr_vld ? arr_err : 3'b000);
    ovr_d = (clr_err ? 1'b0 : ovr_q) | (chr_vld & q_full);
    if (!auto_on)     rts_n_d = ~sw_rts_on;
    else if (!q_full) rts_n_d = 1'b0;
    else if (start_ok) rts_n_d = 1'b1;
    else              rts_n_d = rts_n_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      ovr_q   <= 1'b0;
      rts_n_q <= 1'b1;
    end else begin
      acc_q   <= acc_d;
      ovr_q   <= ovr_d;
      rts_n_q <= rts_n_d;
    end
  end

  assign {st_break, st_frame, st_parity} = cfg_blk_err ? acc_q : head_err;
  assign st_addr    = ~cfg_blk_err & ~q_empty & head_flags.adr;
  assign st_overrun = ovr_q;
  assign irq        = cfg_irq_full ? q_full : ~q_empty;
  assign rts_n      = rts_n_q;

endmodule

// File: rtl/sio_receiver.sv
module sio_receiver
  import sio_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              rxd,
  input  logic [1:0]        cfg_par_mode,
  input  logic              cfg_par_type,
  input  logic              cfg_blk_err,
  input  logic              cfg_irq_full,
  input  logic              cfg_rx_rts_auto,
  input  logic              cfg_tx_rts_auto,
  input  logic              sw_rts_on,
  input  logic              clr_err,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              fifo_full,
  output logic              st_break,
  output logic              st_frame,
  output logic              st_parity,
  output logic              st_addr,
  output logic              st_overrun,
  output logic              irq,
  output logic              rts_n
);

  logic [1:0]        rsync_q;
  logic              rst_sync_n;
  logic              start_ok, chr_vld;
  logic [DATA_W-1:0] chr_data, head_data;
  rx_flags_t         chr_flags, head_flags;
  logic              q_empty, q_full, arr_vld;
  logic [2:0]        arr_err;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sync_n = rsync_q[1];

  sio_rx_deser #(.DATA_W(DATA_W), .OVS(OVS)) u_deser (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .tick     (os_tick),
    .rxd      (rxd),
    .par_sel  (cfg_par_mode),
    .par_kind (cfg_par_type),
    .start_ok (start_ok),
    .chr_vld  (chr_vld),
    .chr_data (chr_data),
    .chr_flags(chr_flags)
  );

  sio_rx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (chr_vld),
    .wr_data   (chr_data),
    .wr_flags  (chr_flags),
    .rd_en     (rd_en),
    .head_data (head_data),
    .head_flags(head_flags),
    .empty     (q_empty),
    .full      (q_full),
    .arr_vld   (arr_vld),
    .arr_err   (arr_err)
  );

  sio_rx_ctl u_ctl (
    .clk            (clk),
    .rst_n          (rst_sync_n),
    .start_ok       (start_ok),
    .chr_vld        (chr_vld),
    .q_empty        (q_empty),
    .q_full         (q_full),
    .arr_vld        (arr_vld),
    .arr_err        (arr_err),
    .head_flags     (head_flags),
    .cfg_blk_err    (cfg_blk_err),
    .cfg_irq_full   (cfg_irq_full),
    .cfg_rx_rts_auto(cfg_rx_rts_auto),
    .cfg_tx_rts_auto(cfg_tx_rts_auto),
    .sw_rts_on      (sw_rts_on),
    .clr_err        (clr_err),
    .st_break       (st_break),
    .st_frame       (st_frame),
    .st_parity      (st_parity),
    .st_addr        (st_addr),
    .st_overrun     (st_overrun),
    .irq            (irq),
    .rts_n          (rts_n)
  );

  assign rd_valid  = ~q_empty;
  assign fifo_full = q_full;
  assign rd_data   = q_empty ? '0 : head_data;

endmodule

// File: rtl/sio_receiver_chk.sv
module sio_receiver_chk (
  input logic clk,
  input logic rst_sync_n,
  input logic cfg_rx_rts_auto,
  input logic cfg_tx_rts_auto,
  input logic cfg_blk_err,
  input logic sw_rts_on,
  input logic rd_en,
  input logic rd_valid,
  input logic fifo_full,
  input logic irq,
  input logic rts_n,
  input logic st_break,
  input logic st_frame,
  input logic st_parity,
  input logic st_addr,
  input logic st_overrun
);

  p_full_holds_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fifo_full && !rd_en) |=> fifo_full);

  p_addr_quiet_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cfg_blk_err |-> !st_addr);

  p_empty_quiet_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!rd_valid && !cfg_blk_err) |-> !(st_break || st_frame || st_parity || st_addr));

  p_ovr_cause_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(st_overrun) |-> $past(fifo_full));

  p_full_irq_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fifo_full |-> irq);

  p_rts_free_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg_rx_rts_auto && !cfg_tx_rts_auto && !fifo_full) |=> !rts_n);

  p_rts_soft_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(cfg_rx_rts_auto && !cfg_tx_rts_auto) |=> (rts_n == !$past(sw_rts_on)));

endmodule

bind sio_receiver sio_receiver_chk u_chk (.*);

// File: tb/sio_receiver_bench.sv
module sio_receiver_bench;

  localparam int CLK_PERIOD = 10;
  localparam int OVS        = 16;
  localparam int DEPTH      = 4;

  logic       clk = 1'b0;
  logic       rst_n, os_tick, rxd;
  logic [1:0] cfg_par_mode;
  logic       cfg_par_type, cfg_blk_err, cfg_irq_full;
  logic       cfg_rx_rts_auto, cfg_tx_rts_auto, sw_rts_on, clr_err, rd_en;
  logic [7:0] rd_data;
  logic       rd_valid, fifo_full, st_break, st_frame, st_parity, st_addr;
  logic       st_overrun, irq, rts_n;

  int  total = 0;
  int  bad   = 0;
  bit  done  = 0;

  logic [7:0] mq_d[$];
  logic [3:0] mq_f[$];   // {brk, fe, pe, adr}
  logic [2:0] m_acc;
  logic       m_ovr;
  logic       m_rts_latch;

  always #(CLK_PERIOD/2) clk = ~clk;

  sio_receiver u_sio_receiver (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
    .cfg_par_mode(cfg_par_mode), .cfg_par_type(cfg_par_type),
    .cfg_blk_err(cfg_blk_err), .cfg_irq_full(cfg_irq_full),
    .cfg_rx_rts_auto(cfg_rx_rts_auto), .cfg_tx_rts_auto(cfg_tx_rts_auto),
    .sw_rts_on(sw_rts_on), .clr_err(clr_err), .rd_en(rd_en),
    .rd_data(rd_data), .rd_valid(rd_valid), .fifo_full(fifo_full),
    .st_break(st_break), .st_frame(st_frame), .st_parity(st_parity),
    .st_addr(st_addr), .st_overrun(st_overrun), .irq(irq), .rts_n(rts_n)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_flags(logic [7:0] d, logic pb, logic stop,
                                           logic [1:0] pm, logic pt);
    logic has_p, pe, adr, fe, brk;
    has_p = (pm != 2'b10);
    pe    = (pm == 2'b00 && pb != ((^d) ^ pt)) || (pm == 2'b01 && pb != pt);
    adr   = (pm == 2'b11) && pb;
    fe    = !stop;
    brk   = !stop && d == 8'h00 && (!has_p || !pb);
    return {brk, fe, pe, adr};
  endfunction

  function automatic logic exp_rts();
    if (!(cfg_rx_rts_auto && !cfg_tx_rts_auto)) return !sw_rts_on;
    if (mq_d.size() < DEPTH) return 1'b0;
    return m_rts_latch;
  endfunction

  task automatic check_all(string req);
    logic       ne;
    logic [3:0] hf;
    logic [2:0] ee;
    ne = (mq_d.size() > 0);
    hf = ne ? mq_f[0] : 4'h0;
    ee = cfg_blk_err ? m_acc : hf[3:1];
    chk(req, "rd_valid", rd_valid, ne);
    chk(req, "rd_data", rd_data, ne ? mq_d[0] : 8'h00);
    chk(req, "st_break", st_break, ee[2]);
    chk(req, "st_frame", st_frame, ee[1]);
    chk(req, "st_parity", st_parity, ee[0]);
    chk(req, "st_addr", st_addr, !cfg_blk_err && hf[0]);
    chk(req, "st_overrun", st_overrun, m_ovr);
    chk(req, "fifo_full", fifo_full, mq_d.size() == DEPTH);
    chk(req, "irq", irq, cfg_irq_full ? (mq_d.size() == DEPTH) : ne);
    chk(req, "rts_n", rts_n, exp_rts());
  endtask

  task automatic send_frame(logic [7:0] d, logic pb, logic stop);
    logic       has_p;
    logic [3:0] f;
    has_p = (cfg_par_mode != 2'b10);
    f = exp_flags(d, pb, stop, cfg_par_mode, cfg_par_type);
    @(negedge clk) rxd = 1'b0;
    repeat (OVS) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = d[i];
      repeat (OVS) @(negedge clk);
    end
    if (has_p) begin
      rxd = pb;
      repeat (OVS) @(negedge clk);
    end
    rxd = stop;
    repeat (OVS) @(negedge clk);
    if (!stop) repeat (OVS) @(negedge clk);
    rxd = 1'b1;
    repeat (OVS) @(negedge clk);
    if (mq_d.size() == DEPTH) begin
      m_ovr = 1'b1;
      if (cfg_rx_rts_auto && !cfg_tx_rts_auto) m_rts_latch = 1'b1;
    end else begin
      if (mq_d.size() == 0) m_acc = m_acc | f[3:1];
      mq_d.push_back(d);
      mq_f.push_back(f);
    end
  endtask

  task automatic good_frame(logic [7:0] d);
    logic pb;
    case (cfg_par_mode)
      2'b00:   pb = (^d) ^ cfg_par_type;
      2'b01:   pb = cfg_par_type;
      default: pb = 1'b0;
    endcase
    send_frame(d, pb, 1'b1);
  endtask

  task automatic read_one();
    @(negedge clk) rd_en = 1'b1;
    @(negedge clk) rd_en = 1'b0;
    @(negedge clk);
    if (mq_d.size() > 0) begin
      void'(mq_d.pop_front());
      void'(mq_f.pop_front());
      if (mq_d.size() > 0) m_acc = m_acc | mq_f[0][3:1];
    end
    m_rts_latch = 1'b0;
  endtask

  task automatic clear_err();
    @(negedge clk) clr_err = 1'b1;
    @(negedge clk) clr_err = 1'b0;
    m_acc = 3'b000;
    m_ovr = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic drain();
    while (mq_d.size() > 0) read_one();
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; os_tick = 1'b1; rxd = 1'b1;
    cfg_par_mode = 2'b00; cfg_par_type = 1'b0; cfg_blk_err = 1'b0;
    cfg_irq_full = 1'b0; cfg_rx_rts_auto = 1'b0; cfg_tx_rts_auto = 1'b0;
    sw_rts_on = 1'b0; clr_err = 1'b0; rd_en = 1'b0;
    m_acc = 3'b000; m_ovr = 1'b0; m_rts_latch = 1'b0;

    // R12: reset state
    repeat (3) @(negedge clk);
    check_all("R12");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_all("R12");

    // R11: software control of rts_n
    sw_rts_on = 1'b1;
    settle();
    check_all("R11");

    // R1: short start pulse rejected, next frame received
    @(negedge clk) rxd = 1'b0;
    repeat (4) @(negedge clk);
    rxd = 1'b1;
    repeat (40) @(negedge clk);
    check_all("R1");
    good_frame(8'hA5);
    check_all("R1");
    read_one();

    // R2: ordering, bit order
    good_frame(8'h01);
    good_frame(8'h80);
    good_frame(8'h3C);
    check_all("R2");
    read_one(); check_all("R2");
    read_one(); check_all("R2");
    read_one(); check_all("R2");

    // R3: parity variants
    send_frame(8'h07, 1'b0, 1'b1); check_all("R3"); read_one();   // even, wrong
    cfg_par_type = 1'b1;
    send_frame(8'h07, 1'b0, 1'b1); check_all("R3"); read_one();   // odd, right
    send_frame(8'h06, 1'b0, 1'b1); check_all("R3"); read_one();   // odd, wrong
    cfg_par_mode = 2'b01;
    send_frame(8'h55, 1'b0, 1'b1); check_all("R3"); read_one();   // forced 1, wrong
    cfg_par_type = 1'b0;
    send_frame(8'h55, 1'b0, 1'b1); check_all("R3"); read_one();   // forced 0, right
    cfg_par_mode = 2'b10;
    good_frame(8'hC3); check_all("R3"); read_one();               // no extra bit

    // R4: multidrop address flag
    cfg_par_mode = 2'b11;
    send_frame(8'h12, 1'b1, 1'b1);
    check_all("R4");
    cfg_blk_err = 1'b1; settle();
    check_all("R4");
    cfg_blk_err = 1'b0; settle();
    read_one();
    send_frame(8'h12, 1'b0, 1'b1); check_all("R4"); read_one();

    // R5: break and plain framing error
    cfg_par_mode = 2'b10;
    send_frame(8'h00, 1'b0, 1'b0); check_all("R5"); read_one();
    send_frame(8'h3C, 1'b0, 1'b0); check_all("R5"); read_one();
    cfg_par_mode = 2'b00;
    send_frame(8'h00, 1'b0, 1'b0); check_all("R5");
    good_frame(8'h44); check_all("R5");
    read_one(); read_one();

    // R6 / R7: status modes
    clear_err();
    cfg_blk_err = 1'b1;
    send_frame(8'h07, 1'b0, 1'b1);      // parity error
    good_frame(8'h08);
    check_all("R7");
    read_one();
    check_all("R7");
    cfg_blk_err = 1'b0; settle();
    check_all("R6");
    cfg_blk_err = 1'b1; settle();
    clear_err();
    check_all("R7");
    read_one();
    cfg_blk_err = 1'b0;

    // R8 / R9 / R10: full queue, overrun, automatic rts
    cfg_rx_rts_auto = 1'b1; cfg_irq_full = 1'b1; settle();
    good_frame(8'h21); good_frame(8'h22); good_frame(8'h23);
    check_all("R9");
    good_frame(8'h24);
    check_all("R9");
    check_all("R10");
    good_frame(8'h25);
    check_all("R8");
    check_all("R10");
    read_one();
    check_all("R10");
    cfg_irq_full = 1'b0; settle();
    check_all("R9");

    // R11: both automatic controls cancel out
    cfg_tx_rts_auto = 1'b1; sw_rts_on = 1'b0; settle();
    check_all("R11");
    sw_rts_on = 1'b1; settle();
    check_all("R11");
    cfg_tx_rts_auto = 1'b0; cfg_rx_rts_auto = 1'b0; settle();
    drain();
    clear_err();
    check_all("R8");

    // random mix
    for (int n = 0; n < 70; n++) begin
      int op;
      op = $urandom % 8;
      if (op < 4) begin
        logic [7:0] d;
        d = $urandom;
        if (($urandom % 6) == 0) d = 8'h00;
        send_frame(d, logic'($urandom % 2), logic'(($urandom % 6) != 0));
        check_all("R3");
      end else if (op < 6) begin
        read_one();
        check_all("R2");
      end else if (op == 6) begin
        clear_err();
        check_all("R7");
      end else begin
        cfg_par_mode = $urandom % 4;
        cfg_par_type = $urandom % 2;
        cfg_blk_err  = $urandom % 2;
        cfg_irq_full = $urandom % 2;
        settle();
        check_all("R6");
      end
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule